// File: doc/BRIEF.md
# Supply Recharge Timer and Monitor

This block paces the recharge pulses that top up a regulated core supply while the chip holds its state in a low-power retention mode. It advances only on a slow 32 kHz tick and raises a one-clock recharge request whenever the selected algorithm calls for one. There are four algorithms: off, a fixed timer, a timer that adapts its period to how the supply held up, and a mode that follows an external comparator directly. Every period is written as a mantissa and an exponent. A second mantissa/exponent pair sets the upper limit on the period.

At each recharge the block records whether the supply was still above its OK threshold. The last four such samples are kept as a shift history. The block also keeps the longest tick gap between two recharges where the later one found the supply still good. Leakage can be judged from this statistic. Software reads both through a small register port and clears the gap by writing the status word.

Top module: `rchg_sched`

## Requirements
- R1: After reset the configuration reads as zero (mode off), the status word reads as zero and no recharge request is raised.
- R2: A write to address 0 stores write-data bits [17:0] as the configuration: mode [17:16], period exponent [15:13], period mantissa [12:8], limit exponent [7:5], limit mantissa [4:0]. A read of address 0 returns exactly these bits, and bits [31:18] read zero.
- R3: In mode 0 no recharge request is ever raised, whatever the tick and sample inputs do.
- R4: In mode 1 the period is (mantissa+1)·2^exponent ticks, clamped to the limit (limit mantissa+1)·2^(limit exponent). A recharge occurs on every tick that completes the period.
- R5: In mode 2 the period starts at the clamped base on each configuration write. Each recharge that finds the supply good adds 2^(period exponent), up to the limit. Each recharge that finds it low halves the period, with a floor of one tick.
- R6: In mode 3 a recharge occurs on every tick where the sample input reports the supply low (0), and on no tick where it reports it good (1).
- R7: At every recharge the 4-bit history in status bits [23:20] shifts left by one place, and bit 20 takes the sample: 1 means good, 0 means low. Without a recharge the history does not change.
- R8: Status bits [15:0] hold the largest tick count between a recharge and the one before it (or reset, or configuration write) over all recharges that found the supply good. The count saturates at 16'hFFFF.
- R9: Any write to address 1 clears the gap statistic to zero whatever the write data, and leaves the history unchanged.
- R10: A configuration write restarts the tick count. A tick in the same cycle as a configuration write produces no recharge. Clock cycles without a tick do not advance the count.
- R11: The recharge request is a registered pulse. It is high for the one clock that follows each recharge tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per 32 kHz period |
| vok | input | 1 | Supply-above-threshold sample, 1 = good |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rchg_req | output | 1 | Recharge request pulse |

## Verification
The assertions assume that `tick` is a single-clock pulse synchronous to `clk` and that `vok` is valid in every tick cycle. They do not assume that ticks are spaced apart, and they do not assume that register writes avoid tick cycles. The stimulus therefore ranges from a tick on every clock to sparse ticks. It draws samples at random, and in places it deliberately places a configuration write and a status write on the same clock as a tick. This covers the collision orderings as well as the usual case.

// File: rtl/rchg_pkg.sv
package rchg_pkg;
    localparam int MAN_W    = 5;
    localparam int EXP_W    = 3;
    localparam int PER_W    = MAN_W + 1 + (1 << EXP_W) - 1;
    localparam int DATA_W   = 32;
    localparam int CFG_W    = 2 + 2 * (MAN_W + EXP_W);
    localparam int HIST_LSB = 20;

    typedef enum logic [1:0] {
        RM_OFF    = 2'd0,
        RM_STATIC = 2'd1,
        RM_ADAPT  = 2'd2,
        RM_COMP   = 2'd3
    } rmode_e;

    typedef struct packed {
        logic [EXP_W-1:0] ex;
        logic [MAN_W-1:0] man;
    } mant_exp_t;

    typedef struct packed {
        rmode_e    mode;
        mant_exp_t per;
        mant_exp_t lim;
    } rcfg_t;

    function automatic logic [PER_W-1:0] me_ticks(input mant_exp_t f);
        logic [PER_W-1:0] b;
        b = PER_W'(f.man) + PER_W'(1);
        return b << f.ex;
    endfunction

    function automatic logic [PER_W-1:0] per_min(input logic [PER_W-1:0] a,
                                                  input logic [PER_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic timed_mode(input rmode_e m);
        return (m == RM_STATIC) || (m == RM_ADAPT);
    endfunction
endpackage

// File: rtl/rchg_regs.sv
module rchg_regs
    import rchg_pkg::*;
#(
    parameter int GAP_W  = 16,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [HIST_W-1:0] hist,
    input  logic [GAP_W-1:0]  gap,
    output rcfg_t             cfg_q,
    output rcfg_t             cfg_d,
    output logic              cfg_wr,
    output logic              stat_clr,
    output logic [DATA_W-1:0] rdata
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:CFG_W];

    assign cfg_wr   = wr_en && !addr;
    assign stat_clr = wr_en && addr;
    assign cfg_d    = cfg_wr ? rcfg_t'(wdata[CFG_W-1:0]) : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[CFG_W-1:0] = cfg_q;
        end else begin
            rdata[GAP_W-1:0]           = gap;
            rdata[HIST_LSB +: HIST_W]  = hist;
        end
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(cfg_q));
endmodule

// File: rtl/rchg_period.sv
module rchg_period
    import rchg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  rcfg_t            cfg_d,
    input  rcfg_t            cfg_q,
    input  logic             evt,
    input  logic             vok,
    output logic [PER_W-1:0] per_use
);
    logic [PER_W-1:0] cur_q, base_d, base_q, lim_q, step, grow, grow_c, half, shrink;

    assign base_d = per_min(me_ticks(cfg_d.per), me_ticks(cfg_d.lim));
    assign lim_q  = me_ticks(cfg_q.lim);
    assign base_q = per_min(me_ticks(cfg_q.per), lim_q);
    assign step   = PER_W'(1) << cfg_q.per.ex;
    assign grow   = cur_q + step;
    assign grow_c = (grow > lim_q) ? lim_q : grow;
    assign half   = cur_q >> 1;
    assign shrink = (half == '0) ? PER_W'(1) : half;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= PER_W'(1);
        else if (cfg_wr)
            cur_q <= base_d;
        else if (evt && cfg_q.mode == RM_ADAPT)
            cur_q <= vok ? grow_c : shrink;
    end

    assign per_use = (cfg_q.mode == RM_ADAPT) ? cur_q : base_q;

    // R5
    cur_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q >= PER_W'(1)) && (cur_q <= lim_q));
    // R5
    shrink_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !vok && cfg_q.mode == RM_ADAPT) |=>
            (cur_q < $past(cur_q)) || (cur_q == PER_W'(1)));
endmodule

// File: rtl/rchg_timer.sv
module rchg_timer
    import rchg_pkg::*;
#(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             vok,
    input  logic             cfg_wr,
    input  rmode_e           mode,
    input  logic [PER_W-1:0] per_use,
    output logic             evt,
    output logic [GAP_W-1:0] elapsed,
    output logic             req
);
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] since_q;
    logic [GAP_W:0]   nxt;
    logic             due;

    assign nxt     = {1'b0, since_q} + (GAP_W+1)'(1);
    assign elapsed = (since_q == GAP_MAX) ? GAP_MAX : nxt[GAP_W-1:0];
    assign due     = nxt >= (GAP_W+1)'(per_use);

    always_comb begin
        evt = 1'b0;
        if (tick && !cfg_wr) begin
            if (timed_mode(mode))    evt = due;
            else if (mode == RM_COMP) evt = !vok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_wr || mode == RM_OFF)
            since_q <= '0;
        else if (tick)
            since_q <= evt ? '0 : elapsed;
    end

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= evt;
    end

    // R10
    evt_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        evt |-> tick);
    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == RM_OFF) |-> !evt);
    // R4
    count_below_period_chk: assert property (@(posedge clk) disable iff (rst)
        timed_mode(mode) |-> (since_q < GAP_W'(per_use)));
    // R11
    req_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(tick));
endmodule

// File: rtl/rchg_monitor.sv
module rchg_monitor #(
    parameter int GAP_W  = 16,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              vok,
    input  logic [GAP_W-1:0]  elapsed,
    input  logic              stat_clr,
    output logic [HIST_W-1:0] hist,
    output logic [GAP_W-1:0]  gap
);
    for (genvar i = 0; i < HIST_W; i++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst)      hist[i] <= 1'b0;
            else if (evt) hist[i] <= (i == 0) ? vok : hist[(i == 0) ? 0 : i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || stat_clr)
            gap <= '0;
        else if (evt && vok && elapsed > gap)
            gap <= elapsed;
    end

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(hist));
    // R9
    gap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> (gap == '0));
    // R8
    gap_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_clr |=> (gap >= $past(gap)));
endmodule

// File: rtl/rchg_sched.sv
module rchg_sched
    import rchg_pkg::*;
#(
    parameter int GAP_W  = 16,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              vok,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rchg_req
);
    rcfg_t             cfg_q, cfg_d;
    logic              cfg_wr, stat_clr, evt;
    logic [PER_W-1:0]  per_use;
    logic [GAP_W-1:0]  elapsed, gap;
    logic [HIST_W-1:0] hist;

    rchg_regs #(.GAP_W(GAP_W), .HIST_W(HIST_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .hist(hist), .gap(gap), .cfg_q(cfg_q), .cfg_d(cfg_d), .cfg_wr(cfg_wr),
        .stat_clr(stat_clr), .rdata(reg_rdata)
    );

    rchg_period u_period (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_d(cfg_d), .cfg_q(cfg_q),
        .evt(evt), .vok(vok), .per_use(per_use)
    );

    rchg_timer #(.GAP_W(GAP_W)) u_timer (
        .clk(clk), .rst(rst), .tick(tick), .vok(vok), .cfg_wr(cfg_wr),
        .mode(cfg_q.mode), .per_use(per_use), .evt(evt), .elapsed(elapsed),
        .req(rchg_req)
    );

    rchg_monitor #(.GAP_W(GAP_W), .HIST_W(HIST_W)) u_mon (
        .clk(clk), .rst(rst), .evt(evt), .vok(vok), .elapsed(elapsed),
        .stat_clr(stat_clr), .hist(hist), .gap(gap)
    );
endmodule

// File: tb/rchg_sched_tb.sv
module rchg_sched_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, vok = 1'b0;
    logic        wr = 1'b0, addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;

    always #2.5 clk = ~clk;

    rchg_sched u_dut (
        .clk(clk), .rst(rst), .tick(tick), .vok(vok), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .rchg_req(req)
    );

    int    total = 0, bad = 0, req_seen = 0;
    string tag = "R1";
    bit    seen_edge = 0, done = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference
    logic [17:0] m_cfg;
    int  m_since, m_cur, m_hist, m_gap;
    bit  m_req;
    int  t_mode, t_lim, t_base, t_use, t_el;
    bit  t_evt, t_wc, t_ws;
    logic [17:0] t_nc;

    function automatic int ticks(input int man, input int ex);
        return (man + 1) << ex;
    endfunction
    function automatic int imin(input int a, input int b);
        return a < b ? a : b;
    endfunction

    always @(posedge clk) begin
        seen_edge = 1;
        if (rst) begin
            m_cfg = '0; m_since = 0; m_cur = 1; m_hist = 0; m_gap = 0; m_req = 0;
        end else begin
            t_mode = int'(m_cfg[17:16]);
            t_lim  = ticks(int'(m_cfg[4:0]), int'(m_cfg[7:5]));
            t_base = imin(ticks(int'(m_cfg[12:8]), int'(m_cfg[15:13])), t_lim);
            t_use  = (t_mode == 2) ? m_cur : t_base;
            t_wc   = wr && !addr;
            t_ws   = wr && addr;
            t_el   = (m_since >= 65535) ? 65535 : m_since + 1;
            t_evt  = 0;
            if (tick && !t_wc) begin
                if (t_mode == 1 || t_mode == 2) t_evt = (m_since + 1 >= t_use);
                else if (t_mode == 3)           t_evt = !vok;
            end
            if (t_ws) m_gap = 0;
            else if (t_evt && vok && t_el > m_gap) m_gap = t_el;
            if (t_evt) m_hist = ((m_hist << 1) | int'(vok)) & 15;
            if (t_wc) begin
                t_nc  = wdata[17:0];
                m_cur = imin(ticks(int'(t_nc[12:8]), int'(t_nc[15:13])),
                             ticks(int'(t_nc[4:0]), int'(t_nc[7:5])));
            end else if (t_evt && t_mode == 2) begin
                if (vok) m_cur = imin(m_cur + (1 << int'(m_cfg[15:13])), t_lim);
                else     m_cur = (m_cur / 2 < 1) ? 1 : m_cur / 2;
            end
            if (t_wc || t_mode == 0) m_since = 0;
            else if (tick)           m_since = t_evt ? 0 : t_el;
            if (t_wc) m_cfg = wdata[17:0];
            m_req = t_evt;
        end
    end

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            chk(req == m_req, "req", longint'(req), longint'(m_req));
            if (!addr)
                chk(rdata == {14'b0, m_cfg}, "cfg read", longint'(rdata), longint'({14'b0, m_cfg}));
            else
                chk(rdata == ((m_hist << 20) | m_gap), "status read",
                    longint'(rdata), longint'((m_hist << 20) | m_gap));
        end
    end

    function automatic logic [31:0] enc(input int mode, input int pe, input int pm,
                                        input int le, input int lm);
        return {14'b0, 2'(mode), 3'(pe), 5'(pm), 3'(le), 5'(lm)};
    endfunction

    task automatic step(input bit t, input bit v);
        tick = t; vok = v; wr = 0;
        @(posedge clk); #1;
        if (req) req_seen++;
    endtask

    task automatic wreg(input bit a, input logic [31:0] d, input bit t, input bit v);
        wr = 1; addr = a; wdata = d; tick = t; vok = v;
        @(posedge clk); #1;
        if (req) req_seen++;
        wr = 0;
    endtask

    // n ticks, idle cycles between, vmode 0 low, 1 good, 2 random
    task automatic run(input int n, input int idle, input int vmode);
        for (int i = 0; i < n; i++) begin
            addr = 1'($urandom_range(0, 1));
            step(1, vmode == 2 ? 1'($urandom_range(0, 1)) : 1'(vmode));
            for (int j = 0; j < idle; j++) step(0, 1'($urandom_range(0, 1)));
        end
    endtask

    int low_cnt;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        tag = "R1";
        addr = 0; #1 chk(rdata == 0, "cfg after reset", longint'(rdata), 0);
        addr = 1; #1 chk(rdata == 0, "status after reset", longint'(rdata), 0);
        chk(req == 0, "req after reset", longint'(req), 0);

        // R2 readback and field isolation
        tag = "R2";
        wreg(0, 32'hABC0_0000 | enc(0, 5, 17, 2, 9), 0, 0);
        addr = 0; #1;
        chk(rdata == enc(0, 5, 17, 2, 9), "cfg readback", longint'(rdata), longint'(enc(0, 5, 17, 2, 9)));

        // R3 mode off
        tag = "R3";
        req_seen = 0;
        run(50, 0, 2);
        chk(req_seen == 0, "requests in off mode", req_seen, 0);

        // R4 static, unclamped period 6
        tag = "R4";
        wreg(0, enc(1, 1, 2, 7, 31), 0, 1);
        req_seen = 0;
        run(60, 0, 1);
        chk(req_seen == 10, "static request count", req_seen, 10);
        // R4 clamped: 88 limited to 20
        wreg(0, enc(1, 3, 10, 2, 4), 0, 1);
        req_seen = 0;
        run(60, 1, 2);
        chk(req_seen == 3, "clamped request count", req_seen, 3);

        // R9 clear, history intact
        tag = "R9";
        wreg(1, 32'hFFFF_FFFF, 0, 0);
        addr = 1; #1;
        chk(rdata[15:0] == 0, "gap cleared", longint'(rdata[15:0]), 0);
        chk(int'(rdata[23:20]) == m_hist, "history kept", longint'(rdata[23:20]), longint'(m_hist));

        // R5 adaptive growth from 4 by 2 up to 20
        tag = "R5";
        wreg(0, enc(2, 1, 1, 2, 4), 0, 1);
        wreg(1, 32'h0, 0, 0);
        req_seen = 0;
        run(128, 0, 1);
        chk(req_seen == 10, "adaptive request count", req_seen, 10);
        tag = "R8";
        addr = 1; #1;
        chk(rdata[15:0] == 20, "max gap", longint'(rdata[15:0]), 20);
        tag = "R7";
        chk(rdata[23:20] == 4'hF, "history all good", longint'(rdata[23:20]), 15);
        tag = "R5";
        run(60, 0, 0);
        run(150, 0, 2);

        // R6 comparator mode
        tag = "R6";
        wreg(0, enc(3, 0, 0, 0, 0), 0, 1);
        req_seen = 0; low_cnt = 0;
        for (int i = 0; i < 100; i++) begin
            bit v = 1'($urandom_range(0, 1));
            if (!v) low_cnt++;
            addr = 1'($urandom_range(0, 1));
            step(1, v);
        end
        chk(req_seen == low_cnt, "comparator request count", req_seen, low_cnt);
        tag = "R7";
        run(40, 2, 2);

        // R10 writes colliding with ticks, sparse ticks
        tag = "R10";
        wreg(0, enc(1, 0, 3, 7, 31), 1, 1);
        req_seen = 0;
        run(12, 3, 1);
        chk(req_seen == 3, "sparse static count", req_seen, 3);
        wreg(0, enc(2, 0, 2, 1, 3), 1, 0);
        wreg(1, 32'h1234, 1, 1);
        run(80, 1, 2);

        // R8 and R11 under mixed traffic
        tag = "R11";
        wreg(0, enc(1, 0, 0, 0, 0), 0, 1);
        run(30, 0, 2);
        tag = "R8";
        wreg(0, enc(2, 2, 3, 3, 7), 0, 1);
        run(200, 0, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 50000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired in %s", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule